// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Centre-Sample Voting

This block turns an asynchronous serial line into parallel characters. A one-cycle strobe, `sample_tick`, arrives sixteen times per bit period. The receiver passes the line through a two-flop synchronizer and waits for a falling edge on an idle (high) line. It then checks that the low level is real by taking a 2-of-3 vote over samples 8, 9 and 10 of the start bit. Every later bit is decided by the same vote over its own centre samples. A frame carries 5 to 9 data bits, sent least significant bit first. An odd or even parity bit may follow the data. The frame ends with a stop bit.

A finished character is placed in a single holding register, and `rx_done` is raised. The error flags for that character are loaded into the same register at the same time: a frame error when the first stop bit reads low, and a parity error when parity checking finds a mismatch. If a new start bit is accepted while the register still holds unread data, an overrun is flagged and the new character replaces the old one. A read strobe empties the register. Dropping `rx_en` flushes the register, clears every flag and abandons any frame in progress.

The controller has five states. HUNT waits for a falling edge and moves to START on one. START moves to DATA when the start vote is low, and returns to HUNT when the vote is high (a rejected start). DATA moves on after the last data bit, to PARITY when parity is enabled and to STOP otherwise. PARITY moves to STOP after its vote. STOP stores the character and returns to HUNT at the centre of the first stop bit. The state changes only on sample ticks.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, and one cycle after `rx_en` is low, `rx_done`, `frame_err`, `parity_err`, `overrun_err` and `rd_data` are all 0.
- R2: A falling edge starts a start bit only when the vote over samples 8, 9 and 10 of that bit is low. A shorter low pulse produces no character, and the receiver goes back to hunting, so the next valid frame is received correctly.
- R3: Each bit takes the majority value of samples 8, 9 and 10 of its sixteen samples. One dissenting sample among the three leaves the bit unchanged, and two dissenting samples flip it. The receiver state advances only on cycles with `sample_tick` high.
- R4: Data bits arrive least significant bit first. `cfg_size` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits, and codes above 4 select 9. Bits of `rd_data` above the character size read 0.
- R5: `cfg_parity` 2'b01 selects odd parity, 2'b10 selects even parity, and 2'b00 or 2'b11 means no parity bit. With parity enabled, `parity_err` is loaded with 1 for a character whose parity bit does not make the count of ones odd (odd mode) or even (even mode), and with 0 otherwise.
- R6: `frame_err` is loaded with 1 when the first stop bit votes low. The receiver hunts again from sample 10 of the first stop bit, so a start bit that follows a single stop bit with no idle time is received.
- R7: `rx_done` rises when a character is stored and stays high until `rd_stb`. While it is high and no new character arrives, `rd_data` holds steady.
- R8: An accepted start bit while `rx_done` is high sets `overrun_err`. The new character overwrites the buffer, and `rd_stb` clears both `rx_done` and `overrun_err`.
- R9: Low `rx_en` flushes the buffer and its flags, and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes the receiver |
| sample_tick | input | 1 | Strobe at 16 times the baud rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_size | input | 3 | Character size code (0..4 gives 5..9 bits) |
| cfg_parity | input | 2 | Parity mode: 01 odd, 10 even, 00/11 none |
| rd_stb | input | 1 | Read strobe; empties the buffer |
| rd_data | output | 9 | Received character, zero-extended |
| rx_done | output | 1 | Unread character present |
| frame_err | output | 1 | First stop bit of the buffered character was low |
| parity_err | output | 1 | Parity mismatch on the buffered character |
| overrun_err | output | 1 | A start bit arrived while the buffer was full |

## Verification
On every cycle, the assertions check that a flush empties the buffer and all flags, and that the buffered data holds steady until a new character is stored. They also check that overrun can only follow a full buffer, that a read clears overrun, and that the controller moves only on sample ticks. The effects that need whole waveforms can only be shown by the bench's scenarios. These include the vote over centre samples (one-sample and two-sample glitches), rejection of a short start pulse, least-significant-first assembly at each size, both parity senses, a low stop bit, back-to-back frames, and a flush in the middle of a frame.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [2:0] {
        RX_HUNT   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP   = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic rx_s,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              line_prev;

    // Synchronizer chain, reset to the idle (mark) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], rxd};
        end
    end

    assign rx_s = chain[STAGES-1];

    // The line level seen at the previous sample tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
        end else if (tick) begin
            line_prev <= rx_s;
        end
    end

    assign fall = tick & line_prev & ~rx_s;

endmodule

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler #(
    parameter int unsigned OSR        = 16,
    parameter int unsigned MID_SAMPLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic arm,
    input  logic run,
    input  logic rx_s,
    output logic mid,
    output logic vote
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] IDX_A = CNT_W'(MID_SAMPLE - 1);
    localparam logic [CNT_W-1:0] IDX_B = CNT_W'(MID_SAMPLE);
    localparam logic [CNT_W-1:0] IDX_C = CNT_W'(MID_SAMPLE + 1);
    localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(OSR - 1);

    // cnt holds the number of samples already taken in the current bit.
    logic [CNT_W-1:0] cnt;
    logic             smp_a;
    logic             smp_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            smp_a <= 1'b0;
            smp_b <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
        end else if (tick) begin
            if (arm) begin
                cnt <= CNT_W'(1);
            end else if (run) begin
                cnt <= (cnt == IDX_LAST) ? '0 : cnt + CNT_W'(1);
                if (cnt == IDX_A) smp_a <= rx_s;
                if (cnt == IDX_B) smp_b <= rx_s;
            end
        end
    end

    // The third centre sample is taken live on the deciding tick.
    assign mid  = tick & run & ~arm & (cnt == IDX_C);
    assign vote = (smp_a & smp_b) | (smp_a & rx_s) | (smp_b & rx_s);

endmodule

// File: rtl/uart_os_rx_buffer.sv
module uart_os_rx_buffer #(
    parameter int unsigned DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          commit,
    input  logic [DW-1:0] c_data,
    input  logic          c_fe,
    input  logic          c_pe,
    input  logic          start_ok,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          fe,
    output logic          pe,
    output logic          ovr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
        end else if (flush) begin
            data <= '0;
            full <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
        end else if (commit) begin
            data <= c_data;
            full <= 1'b1;
            fe   <= c_fe;
            pe   <= c_pe;
        end else if (rd) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (flush || rd) begin
            ovr <= 1'b0;
        end else if (start_ok && full) begin
            ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned MID_SAMPLE  = 8,
    parameter int unsigned MIN_BITS    = 5,
    parameter int unsigned MAX_BITS    = 9,
    parameter int unsigned SIZE_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                sample_tick,
    input  logic                rxd,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic [1:0]          cfg_parity,
    input  logic                rd_stb,
    output logic [MAX_BITS-1:0] rd_data,
    output logic                rx_done,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun_err
);

    localparam int unsigned IDX_W     = $clog2(MAX_BITS);
    localparam int unsigned SIZE_SPAN = MAX_BITS - MIN_BITS;

    function automatic logic [IDX_W-1:0] last_index(input logic [SIZE_W-1:0] code);
        if (int'(code) > SIZE_SPAN) begin
            return IDX_W'(MAX_BITS - 1);
        end
        return IDX_W'(MIN_BITS - 1 + int'(code));
    endfunction

    rx_state_e           state;
    rx_state_e           state_nxt;
    logic                rx_s;
    logic                fall;
    logic                mid;
    logic                vote;
    logic                arm;
    logic                start_ok;
    logic                commit;
    logic                run;
    logic                flush;
    logic [MAX_BITS-1:0] shreg;
    logic [IDX_W-1:0]    bit_idx;
    logic [IDX_W-1:0]    frm_last;
    par_mode_e           frm_par;
    logic                par_on;
    logic                par_acc;
    logic                par_bad;

    assign flush  = ~rx_en;
    assign run    = (state != RX_HUNT);
    assign par_on = (frm_par == PAR_ODD) || (frm_par == PAR_EVEN);

    uart_os_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick),
        .rxd   (rxd),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    uart_os_rx_sampler #(
        .OSR        (OSR),
        .MID_SAMPLE (MID_SAMPLE)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .tick  (sample_tick),
        .arm   (arm),
        .run   (run),
        .rx_s  (rx_s),
        .mid   (mid),
        .vote  (vote)
    );

    // Next-state logic and the per-cycle strobes to the datapath.
    always_comb begin
        state_nxt = state;
        arm       = 1'b0;
        start_ok  = 1'b0;
        commit    = 1'b0;
        unique case (state)
            RX_HUNT: begin
                if (fall) begin
                    arm       = 1'b1;
                    state_nxt = RX_START;
                end
            end
            RX_START: begin
                if (mid) begin
                    if (!vote) begin
                        start_ok  = 1'b1;
                        state_nxt = RX_DATA;
                    end else begin
                        state_nxt = RX_HUNT;
                    end
                end
            end
            RX_DATA: begin
                if (mid && (bit_idx == frm_last)) begin
                    state_nxt = par_on ? RX_PARITY : RX_STOP;
                end
            end
            RX_PARITY: begin
                if (mid) begin
                    state_nxt = RX_STOP;
                end
            end
            RX_STOP: begin
                if (mid) begin
                    commit    = 1'b1;
                    state_nxt = RX_HUNT;
                end
            end
            default: begin
                state_nxt = RX_HUNT;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_HUNT;
        end else if (flush) begin
            state <= RX_HUNT;
        end else begin
            state <= state_nxt;
        end
    end

    // Frame assembly: configuration latch, shift register and parity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_idx  <= '0;
            frm_last <= '0;
            frm_par  <= PAR_NONE;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
        end else if (flush) begin
            shreg    <= '0;
            bit_idx  <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
        end else begin
            if (start_ok) begin
                shreg    <= '0;
                bit_idx  <= '0;
                par_acc  <= 1'b0;
                par_bad  <= 1'b0;
                frm_last <= last_index(cfg_size);
                frm_par  <= par_mode_e'(cfg_parity);
            end
            if ((state == RX_DATA) && mid) begin
                shreg[bit_idx] <= vote;
                par_acc        <= par_acc ^ vote;
                bit_idx        <= bit_idx + IDX_W'(1);
            end
            if ((state == RX_PARITY) && mid) begin
                par_bad <= (frm_par == PAR_EVEN) ? (vote != par_acc)
                                                 : (vote == par_acc);
            end
        end
    end

    uart_os_rx_buffer #(
        .DW (MAX_BITS)
    ) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .commit   (commit),
        .c_data   (shreg),
        .c_fe     (~vote),
        .c_pe     (par_bad),
        .start_ok (start_ok),
        .rd       (rd_stb),
        .data     (rd_data),
        .full     (rx_done),
        .fe       (frame_err),
        .pe       (parity_err),
        .ovr      (overrun_err)
    );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk
    import uart_os_rx_pkg::*;
#(
    parameter int unsigned DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          sample_tick,
    input logic          rd_stb,
    input logic [DW-1:0] rd_data,
    input logic          rx_done,
    input logic          frame_err,
    input logic          parity_err,
    input logic          overrun_err,
    input logic          commit,
    input rx_state_e     state
);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_done && !frame_err && !parity_err && !overrun_err && (rd_data == '0)));

    a_r8_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_stb) |=> !overrun_err);

    a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $rose(overrun_err)) |-> $past(rx_done));

    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_done && !commit) |=> $stable(rd_data));

    a_r7_done_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(commit));

    a_r3_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !sample_tick) |=> $stable(state));

endmodule

bind uart_os_rx uart_os_rx_chk #(.DW(MAX_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .sample_tick (sample_tick),
    .rd_stb      (rd_stb),
    .rd_data     (rd_data),
    .rx_done     (rx_done),
    .frame_err   (frame_err),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .commit      (commit),
    .state       (state)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;

    typedef struct packed {
        logic [8:0] d;
        logic       fe;
        logic       pe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] cfg_size = 3'd3;
    logic [1:0] cfg_parity = 2'b00;
    logic       rd_stb = 1'b0;
    logic [8:0] rd_data;
    logic       rx_done;
    logic       frame_err;
    logic       parity_err;
    logic       overrun_err;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   auto_rd = 1'b1;
    bit   finished = 1'b0;
    exp_t q[$];
    int   tcnt = 0;

    uart_os_rx i_uart_os_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .sample_tick (sample_tick),
        .rxd         (rxd),
        .cfg_size    (cfg_size),
        .cfg_parity  (cfg_parity),
        .rd_stb      (rd_stb),
        .rd_data     (rd_data),
        .rx_done     (rx_done),
        .frame_err   (frame_err),
        .parity_err  (parity_err),
        .overrun_err (overrun_err)
    );

    always #4 clk = ~clk;

    // Sample tick: one clock in four, changed away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            tcnt        = (tcnt + 1) % 4;
            sample_tick = (tcnt == 3);
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (sample_tick !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic drive_seg(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        wait_ticks(n);
    endtask

    // One bit of 16 samples; samples gs .. gs+glen-1 take the opposite level.
    task automatic drive_bit(input logic v, input int gs, input int glen);
        if (glen == 0) begin
            drive_seg(v, 16);
        end else begin
            drive_seg(v, gs - 1);
            drive_seg(~v, glen);
            drive_seg(v, 16 - (gs - 1) - glen);
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input int pm, input bit pflip,
                              input bit stop_v, input int gpos, input int gs, input int glen,
                              input int lead, input int idle);
        logic [9:0] m;
        logic       par;
        int         npos;
        cfg_size   = 3'(nb - 5);
        cfg_parity = 2'(pm);
        m    = (10'd1 << nb) - 10'd1;
        par  = ^(d & m[8:0]);
        if (pm == 1) par = ~par;
        par  = par ^ pflip;
        npos = 2 + nb + ((pm == 1 || pm == 2) ? 1 : 0);
        if (lead > 0) drive_seg(1'b1, lead);
        for (int p = 0; p < npos; p++) begin
            logic v;
            if (p == 0)                                  v = 1'b0;
            else if (p <= nb)                            v = d[p-1];
            else if ((pm == 1 || pm == 2) && p == nb + 1) v = par;
            else                                         v = stop_v;
            if (p == gpos) drive_bit(v, gs, glen);
            else           drive_bit(v, 0, 0);
        end
        if (idle > 0) drive_seg(1'b1, idle);
    endtask

    task automatic expect_char(input logic [8:0] d, input logic fe, input logic pe);
        exp_t e;
        e.d  = d;
        e.fe = fe;
        e.pe = pe;
        q.push_back(e);
    endtask

    task automatic drain(input string req);
        wait_ticks(4);
        @(negedge clk);
        chk(req, "characters still expected", 32'(q.size()), 32'd0);
    endtask

    task automatic manual_read();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every new character and reads it out.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && rx_done === 1'b1) begin
                if (q.size() == 0) begin
                    chk("R7", "unexpected character", 32'(rd_data), 32'h0);
                    chk("R7", "unexpected rx_done", 32'(rx_done), 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R4", "rd_data", 32'(rd_data), 32'(e.d));
                    chk("R6", "frame_err", 32'(frame_err), 32'(e.fe));
                    chk("R5", "parity_err", 32'(parity_err), 32'(e.pe));
                end
                rd_stb = 1'b1;
                @(negedge clk);
                rd_stb = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rx_done after reset", 32'(rx_done), 32'h0);
        chk("R1", "flags after reset", 32'({frame_err, parity_err, overrun_err}), 32'h0);
        chk("R1", "rd_data after reset", 32'(rd_data), 32'h0);

        // R4: sizes and bit order, no parity
        expect_char(9'h0A5, 1'b0, 1'b0); send_frame(9'h0A5, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h03C, 1'b0, 1'b0); send_frame(9'h03C, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h016, 1'b0, 1'b0); send_frame(9'h1F6, 5, 0, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h001, 1'b0, 1'b0); send_frame(9'h181, 7, 0, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h1A5, 1'b0, 1'b0); send_frame(9'h1A5, 9, 0, 0, 1, -1, 0, 0, 2, 2);
        drain("R4");

        // R5: parity senses and mismatches
        expect_char(9'h0B3, 1'b0, 1'b0); send_frame(9'h0B3, 8, 2, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h0B3, 1'b0, 1'b1); send_frame(9'h0B3, 8, 2, 1, 1, -1, 0, 0, 2, 2);
        expect_char(9'h04E, 1'b0, 1'b0); send_frame(9'h04E, 8, 1, 0, 1, -1, 0, 0, 2, 2);
        expect_char(9'h04E, 1'b0, 1'b1); send_frame(9'h04E, 8, 1, 1, 1, -1, 0, 0, 2, 2);
        expect_char(9'h1C1, 1'b0, 1'b1); send_frame(9'h1C1, 9, 1, 1, 1, -1, 0, 0, 2, 2);
        expect_char(9'h015, 1'b0, 1'b0); send_frame(9'h015, 6, 2, 0, 1, -1, 0, 0, 2, 2);
        drain("R5");

        // R6: low stop bit, then back-to-back frames with one stop bit
        expect_char(9'h05A, 1'b1, 1'b0); send_frame(9'h05A, 8, 0, 0, 0, -1, 0, 0, 2, 4);
        expect_char(9'h011, 1'b0, 1'b0); send_frame(9'h011, 8, 0, 0, 1, -1, 0, 0, 2, 0);
        expect_char(9'h0FE, 1'b0, 1'b0); send_frame(9'h0FE, 8, 0, 0, 1, -1, 0, 0, 0, 0);
        expect_char(9'h080, 1'b0, 1'b0); send_frame(9'h080, 8, 0, 0, 1, -1, 0, 0, 0, 2);
        drain("R6");

        // R3: single dissenting centre sample is outvoted, two flip the bit
        expect_char(9'h000, 1'b0, 1'b0); send_frame(9'h000, 8, 0, 0, 1, 4, 9, 1, 2, 2);
        expect_char(9'h0FF, 1'b0, 1'b0); send_frame(9'h0FF, 8, 0, 0, 1, 2, 10, 1, 2, 2);
        expect_char(9'h008, 1'b0, 1'b0); send_frame(9'h000, 8, 0, 0, 1, 4, 8, 2, 2, 2);
        expect_char(9'h0DF, 1'b0, 1'b0); send_frame(9'h0FF, 8, 0, 0, 1, 6, 9, 2, 2, 2);
        expect_char(9'h0C3, 1'b0, 1'b0); send_frame(9'h0C3, 8, 0, 0, 1, 0, 9, 1, 2, 2);
        drain("R3");

        // R2: short start pulse rejected, next frame still received
        drive_seg(1'b1, 2);
        drive_seg(1'b0, 3);
        drive_seg(1'b1, 40);
        @(negedge clk);
        chk("R2", "rx_done after short start", 32'(rx_done), 32'h0);
        expect_char(9'h069, 1'b0, 1'b0); send_frame(9'h069, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        drain("R2");

        // R7: buffer held until read
        auto_rd = 1'b0;
        send_frame(9'h12D, 9, 0, 0, 1, -1, 0, 0, 2, 2);
        wait_ticks(20);
        @(negedge clk);
        chk("R7", "rx_done held", 32'(rx_done), 32'h1);
        chk("R7", "rd_data held", 32'(rd_data), 32'h12D);
        manual_read();
        chk("R7", "rx_done after read", 32'(rx_done), 32'h0);

        // R8: overrun while full, overwrite, read clears
        send_frame(9'h033, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        @(negedge clk);
        chk("R8", "overrun before second frame", 32'(overrun_err), 32'h0);
        send_frame(9'h0CC, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        @(negedge clk);
        chk("R8", "overrun set", 32'(overrun_err), 32'h1);
        chk("R8", "rd_data overwritten", 32'(rd_data), 32'h0CC);
        manual_read();
        chk("R8", "overrun after read", 32'(overrun_err), 32'h0);
        chk("R8", "rx_done after read", 32'(rx_done), 32'h0);

        // R9: flush with flags set
        send_frame(9'h0A0, 8, 2, 1, 0, -1, 0, 0, 2, 4);
        @(negedge clk);
        chk("R9", "flags before flush", 32'({rx_done, frame_err, parity_err}), 32'h7);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "rx_done after flush", 32'(rx_done), 32'h0);
        chk("R9", "flags after flush", 32'({frame_err, parity_err, overrun_err}), 32'h0);
        chk("R1", "rd_data with rx_en low", 32'(rd_data), 32'h0);
        rx_en = 1'b1;

        // R9: frame abandoned when disabled part way through
        cfg_size   = 3'd3;
        cfg_parity = 2'b00;
        drive_seg(1'b1, 2);
        drive_seg(1'b0, 16);
        drive_seg(1'b1, 16);
        drive_seg(1'b0, 8);
        @(negedge clk);
        rx_en = 1'b0;
        drive_seg(1'b1, 20);
        @(negedge clk);
        rx_en = 1'b1;
        drive_seg(1'b1, 200);
        @(negedge clk);
        chk("R9", "no character from abandoned frame", 32'(rx_done), 32'h0);
        auto_rd = 1'b1;
        expect_char(9'h05F, 1'b0, 1'b0); send_frame(9'h05F, 8, 0, 0, 1, -1, 0, 0, 2, 2);
        drain("R9");

        finish_run();
    end

endmodule